// File: doc/BRIEF.md
# Digital Frequency Lock Detector

This block decides whether a synthesized clock is running at its programmed frequency. It works entirely in the reference-clock domain. The feedback side supplies a toggle line that changes level once per (prescaled) feedback event. A two-stage synchroniser brings that line in, and an edge detector turns each change into one event. Events are counted over a fixed window of reference cycles. At the end of each window the total is compared with an expected count, computed from the multiplier and pre-divider settings as multiplier times window length divided by pre-divider.

The lock decision has hysteresis. Acquiring lock needs two consecutive windows inside a narrow band around the expected count. Once locked, the flag stays set through moderate deviation, and a single window outside a much wider band clears it. Whenever the divider settings change, the surrounding logic raises a strobe. The strobe clears the flag at once, restarts the window and discards any partial acquisition progress, so lock has to be earned again through the narrow test. The block has no mode input: measurement and flag updates run the same way whether or not the synthesized clock is in use downstream.

Top module: `freq_lock_detect`

## Requirements
- R1: An active-low asynchronous reset clears the lock flag, the acquisition progress and the event count, and restarts the window at its first cycle.
- R2: A window counts as in-band for acquisition only if |count - E| <= floor(E/32), where E is the expected count.
- R3: The lock flag rises only at the end of the second of two consecutive in-band windows, with no strobe between them. A single in-band window never sets it.
- R4: While locked, a window with |count - E| <= floor(E/8) + floor(E/32) leaves the flag set, even if it is outside the acquisition band.
- R5: While locked, one window with |count - E| > floor(E/8) + floor(E/32) clears the flag at that window's end.
- R6: A high `cfg_chg` sampled on a clock edge clears the flag at that edge, clears acquisition progress and restarts the window, so a fresh lock needs two full windows afterwards.
- R7: E = floor(`mult` * WIN / `prediv`), with WIN = 256 reference cycles by default, evaluated with the settings present when the window ends.
- R8: A `prediv` value of zero is treated as a divide-by-one.
- R9: Each level change of `fb_tgl` counts as exactly one event, through two synchroniser stages. Changes may arrive as often as every reference cycle. A window is exactly WIN reference cycles long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fb_tgl | input | 1 | Feedback toggle line; each level change is one event |
| mult | input | 8 | Programmed multiplier |
| prediv | input | 4 | Programmed pre-divider (0 acts as 1) |
| cfg_chg | input | 1 | Strobe raised when the divider settings change |
| lock | output | 1 | Lock flag |

## Verification
A corrupt window counter or event count shows up as a lock decision taken on the wrong total. That error is visible on `lock` at the next window boundary at the latest, so at most 256 cycles after it arises. A wrong acquisition-progress bit makes `lock` rise one window early or one window late. A strobe that fails to clear state leaves `lock` high on the cycle right after `cfg_chg`. The bench compares `lock` every cycle against a behavioural model fed the same toggle stream, so any of these faults is reported within one window.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  localparam int unsigned ACQ_SHIFT = 5;
  localparam int unsigned REL_SHIFT = 3;

  function automatic int unsigned expected_count(int unsigned m, int unsigned d,
                                                 int unsigned w);
    int unsigned dd;
    dd = (d == 0) ? 1 : d;
    return (m * w) / dd;
  endfunction

  function automatic int unsigned abs_diff(int unsigned a, int unsigned b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic logic within_acquire(int unsigned cnt, int unsigned e);
    return abs_diff(cnt, e) <= (e >> ACQ_SHIFT);
  endfunction

  function automatic logic beyond_release(int unsigned cnt, int unsigned e);
    return abs_diff(cnt, e) > ((e >> REL_SHIFT) + (e >> ACQ_SHIFT));
  endfunction
endpackage

// File: rtl/lkd_edge_sync.sv
module lkd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic ev
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= tgl_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];

  assign ev = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/lkd_window.sv
module lkd_window #(
  parameter int WIN   = 256,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             ev,
  output logic             done,
  output logic [CNT_W-1:0] total
);
  localparam int WIN_W = (WIN > 1) ? $clog2(WIN) : 1;

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last  = (win_q == WIN_W'(WIN - 1));
  assign done  = last & ~restart;
  assign total = cnt_q + CNT_W'(ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (restart || last) begin
      win_q <= '0;
      cnt_q <= '0;
    end else begin
      win_q <= win_q + 1'b1;
      cnt_q <= total;
    end
  end
endmodule

// File: rtl/lkd_judge.sv
module lkd_judge #(
  parameter int CNT_W = 9,
  parameter int EXP_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             done,
  input  logic [CNT_W-1:0] total,
  input  logic [EXP_W-1:0] expected,
  output logic             in_tight,
  output logic             out_wide,
  output logic             lock
);
  logic lock_q, streak_q;

  assign in_tight = lkd_pkg::within_acquire(32'(total), 32'(expected));
  assign out_wide = lkd_pkg::beyond_release(32'(total), 32'(expected));
  assign lock     = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      streak_q <= 1'b0;
    end else if (restart) begin
      lock_q   <= 1'b0;
      streak_q <= 1'b0;
    end else if (done) begin
      if (lock_q) begin
        if (out_wide) begin
          lock_q   <= 1'b0;
          streak_q <= 1'b0;
        end
      end else if (in_tight) begin
        if (streak_q) lock_q <= 1'b1;
        streak_q <= 1'b1;
      end else begin
        streak_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/freq_lock_detect.sv
module freq_lock_detect #(
  parameter int WIN    = 256,
  parameter int MUL_W  = 8,
  parameter int DIV_W  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fb_tgl,
  input  logic [MUL_W-1:0] mult,
  input  logic [DIV_W-1:0] prediv,
  input  logic             cfg_chg,
  output logic             lock
);
  localparam int CNT_W = $clog2(WIN + 1);
  localparam int EXP_W = MUL_W + $clog2(WIN) + 1;

  logic             fb_event;
  logic             win_done;
  logic [CNT_W-1:0] win_total;
  logic [EXP_W-1:0] exp_count;
  logic             in_tight;
  logic             out_wide;

  assign exp_count = EXP_W'(lkd_pkg::expected_count(32'(mult), 32'(prediv), 32'(WIN)));

  lkd_edge_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .tgl_in(fb_tgl), .ev(fb_event)
  );

  lkd_window #(.WIN(WIN), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst_n(rst_n), .restart(cfg_chg), .ev(fb_event),
    .done(win_done), .total(win_total)
  );

  lkd_judge #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .restart(cfg_chg), .done(win_done),
    .total(win_total), .expected(exp_count),
    .in_tight(in_tight), .out_wide(out_wide), .lock(lock)
  );
endmodule

// File: rtl/freq_lock_detect_chk.sv
module freq_lock_detect_chk #(
  parameter int WIN = 256
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_chg,
  input logic win_done,
  input logic in_tight,
  input logic out_wide,
  input logic lock
);
  logic [31:0] gap_q;
  logic        prev_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= '0;
      prev_ok_q <= 1'b0;
    end else begin
      gap_q <= (win_done || cfg_chg) ? '0 : gap_q + 1;
      if (cfg_chg)       prev_ok_q <= 1'b0;
      else if (win_done) prev_ok_q <= in_tight;
    end
  end

  p_acq_tight_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(win_done && in_tight));

  p_acq_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && !lock && in_tight && !prev_ok_q) |=> !lock);

  p_hold_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && win_done && !out_wide && !cfg_chg) |=> lock);

  p_drop_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && win_done && out_wide) |=> !lock);

  p_force_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !lock);

  p_win_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> (gap_q == 32'(WIN - 1)));
endmodule

bind freq_lock_detect freq_lock_detect_chk #(.WIN(WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_chg(cfg_chg), .win_done(win_done),
  .in_tight(in_tight), .out_wide(out_wide), .lock(lock)
);

// File: tb/tb_freq_lock_detect.sv
module tb_freq_lock_detect;
  localparam int WIN = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fb_tgl = 1'b0;
  logic [7:0] mult = 8'd1;
  logic [3:0] prediv = 4'd4;
  logic       cfg_chg = 1'b0;
  logic       lock;

  int errors = 0;
  int checks = 0;
  int rate = 256;
  int acc = 0;
  bit finished = 0;

  // behavioural model state
  int h1 = 0, h2 = 0, h3 = 0;
  int m_win = 0, m_cnt = 0, m_streak = 0;
  bit m_lock = 0;

  freq_lock_detect dut (
    .clk(clk), .rst_n(rst_n), .fb_tgl(fb_tgl), .mult(mult),
    .prediv(prediv), .cfg_chg(cfg_chg), .lock(lock)
  );

  always #4 clk = ~clk;

  // feedback toggle generator: rate/1024 changes per cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      acc = 0;
    end else begin
      acc = acc + rate;
      if (acc >= 1024) begin
        acc = acc - 1024;
        fb_tgl = ~fb_tgl;
      end
    end
  end

  // cycle-level model
  always @(posedge clk) begin
    int ev, e, d, tot, diff;
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0;
      m_win = 0; m_cnt = 0; m_streak = 0; m_lock = 0;
    end else begin
      ev = (h2 != h3) ? 1 : 0;
      h3 = h2; h2 = h1; h1 = int'(fb_tgl);
      if (cfg_chg) begin
        m_lock = 0; m_streak = 0; m_win = 0; m_cnt = 0;
      end else if (m_win == WIN - 1) begin
        d = (prediv == 0) ? 1 : int'(prediv);
        e = (int'(mult) * WIN) / d;
        tot = m_cnt + ev;
        diff = (tot > e) ? tot - e : e - tot;
        if (m_lock) begin
          if (diff > e / 8 + e / 32) begin
            m_lock = 0; m_streak = 0;
          end
        end else if (diff * 32 <= e) begin
          if (m_streak == 1) m_lock = 1;
          m_streak = 1;
        end else begin
          m_streak = 0;
        end
        m_win = 0; m_cnt = 0;
      end else begin
        m_win = m_win + 1;
        m_cnt = m_cnt + ev;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (lock !== m_lock) begin
        errors++;
        $display("FAIL model (R2 R3 R4 R5 R6 R7 R9): lock=%0b expected=%0b at %0t",
                 lock, m_lock, $time);
      end
    end
  end

  task automatic check_lock(input bit exp, input string req);
    checks++;
    if (lock !== exp) begin
      errors++;
      $display("FAIL %s: lock=%0b expected=%0b at %0t", req, lock, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_cfg();
    cfg_chg = 1'b1;
    @(negedge clk);
    cfg_chg = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    check_lock(1'b0, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    // R2 R3: exact rate, expected 64
    wait_cyc(WIN + 10);
    check_lock(1'b0, "R3 one window");
    wait_cyc(WIN);
    check_lock(1'b1, "R3 two windows");
    // R4: ~58 events, inside wide band
    rate = 232;
    wait_cyc(3 * WIN);
    check_lock(1'b1, "R4 hold");
    // R5: ~50 events
    rate = 200;
    wait_cyc(2 * WIN + 10);
    check_lock(1'b0, "R5 drop");
    // R2: wide-band rate does not acquire
    rate = 232;
    wait_cyc(3 * WIN);
    check_lock(1'b0, "R2 no acquire");
    rate = 240;
    wait_cyc(3 * WIN);
    check_lock(1'b0, "R2 no acquire 60");
    rate = 260;
    wait_cyc(3 * WIN);
    check_lock(1'b1, "R2 acquire 65");
    // R6
    wait_cyc(37);
    pulse_cfg();
    check_lock(1'b0, "R6 immediate");
    wait_cyc(265);
    check_lock(1'b0, "R6 one window");
    wait_cyc(WIN);
    check_lock(1'b1, "R6 reacquire");
    // R7: mult 3 / prediv 8 -> 96
    mult = 8'd3; prediv = 4'd8;
    pulse_cfg();
    wait_cyc(3 * WIN);
    check_lock(1'b0, "R7 old rate");
    rate = 384;
    wait_cyc(3 * WIN);
    check_lock(1'b1, "R7 new rate");
    // R8 R9: prediv 0 -> 256, toggle every cycle
    mult = 8'd1; prediv = 4'd0;
    rate = 1024;
    pulse_cfg();
    wait_cyc(2 * WIN + 10);
    check_lock(1'b1, "R8 R9 zero divider");
    // R1 mid-run reset
    rst_n = 1'b0;
    @(negedge clk);
    check_lock(1'b0, "R1 mid reset");
    rst_n = 1'b1;
    wait_cyc(2 * WIN + 10);
    check_lock(1'b1, "R1 relock after reset");
    finish_run();
  end
endmodule